// File: doc/BRIEF.md
# Periodic Interval Timer with Missed-Tick Tally

This block produces a periodic interrupt for a small processor system, typically the base tick of an operating system. An internal prescaler divides the main clock by sixteen. Each prescaled tick advances a 20-bit interval counter, which runs from zero up to a programmed period value and then returns to zero. Every return to zero sets a pending flag and adds one to a 12-bit tally of elapsed periods. Software that is late to service the interrupt can therefore see how many periods it missed, and no tick is lost.

Software reaches the block through a simple word-addressed register bus with four locations. A mode word holds the period value and the two enables. A status word shows whether a period is pending. Two count words return the current counter value and the tally. Reading the first count word acknowledges the interrupt. Reading the second one has no side effects. The interrupt output is a level signal. When the timer enable is cleared, the counter finishes the period in progress, stops at zero and waits there.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset, all four registers read as zero and `irq` is low.
- R2: Register index 0 is the mode word, with the period value PIV in bits [19:0], the timer enable in bit 24 and the interrupt enable in bit 25. A write to it reads back unchanged in those fields, and all other bits read as zero.
- R3: While the timer runs, the counter field CPIV advances once every 16 clocks and steps 0, 1, …, PIV, 0, … . One period therefore lasts 16·(PIV+1) clocks, counted from the write that enables the timer.
- R4: Each return of CPIV to zero sets bit 0 of the status word (index 1) and adds one to the tally PICNT. Index 2 (acknowledging count word) and index 3 (image count word) both carry CPIV in bits [19:0] and PICNT in bits [31:20].
- R5: A read of index 2 returns the current fields and then clears PICNT and the status bit. A read of index 3 returns the same fields and leaves both unchanged.
- R6: If a period ends in the same cycle as a read of index 2, that period counts toward the new interval: PICNT becomes 1 and the status bit stays set.
- R7: PICNT saturates at 4095 and does not wrap.
- R8: `irq` is high exactly while the status bit and the interrupt enable are both set. It stays high until an acknowledging read.
- R9: When the timer enable is cleared, the counter completes its current period and then holds at zero. The prescaler restarts from zero on the next enable, so the next period again lasts 16·(PIV+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe for the addressed register |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word index: 0 mode, 1 status, 2 acknowledging count, 3 image count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the strobe cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The two functions that can fall in the same cycle are the end of a period and the acknowledging read. The bench computes when a period ends from the cycle of the enabling write. It places a read of index 2 in the last cycle of a period, so that the wrap and the clear happen at the same clock edge. It then reads the image word and expects PICNT equal to 1 with the status bit and `irq` still high. A design that lets the clear win would show 0 and a low interrupt.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [1:0] {
      SEL_MODE  = 2'd0,
      SEL_STAT  = 2'd1,
      SEL_VALUE = 2'd2,
      SEL_IMAGE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick,
   output logic at_zero
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

   initial begin
      if (DIV < 2) $error("pit_prescaler: DIV must be at least 2");
   end

   logic [PW-1:0] cnt;

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n || !run) cnt <= '0;
            else                cnt <= cnt + 1'b1;
         end
         assign tick = run && (&cnt);
      end else begin : g_mod
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         always_ff @(posedge clk) begin
            if (!rst_n || !run)  cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate

   assign at_zero = (cnt == '0);
endmodule

// File: rtl/pit_interval_counter.sv
module pit_interval_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] piv,
   output logic [CNT_W-1:0] cpiv,
   output logic             wrap
);
   initial begin
      if (CNT_W < 1) $error("pit_interval_counter: CNT_W must be positive");
   end

   logic at_limit;
   assign at_limit = (cpiv == piv);
   assign wrap     = tick && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n)        cpiv <= '0;
      else if (wrap)     cpiv <= '0;
      else if (tick)     cpiv <= cpiv + 1'b1;
   end
endmodule

// File: rtl/pit_period_tally.sv
module pit_period_tally #(
   parameter int TALLY_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wrap,
   input  logic               ack,
   output logic [TALLY_W-1:0] picnt,
   output logic               pending
);
   initial begin
      if (TALLY_W < 1) $error("pit_period_tally: TALLY_W must be positive");
   end

   localparam logic [TALLY_W-1:0] TOP = {TALLY_W{1'b1}};
   localparam logic [TALLY_W-1:0] ONE = TALLY_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         picnt   <= '0;
         pending <= 1'b0;
      end else if (ack) begin
         picnt   <= wrap ? ONE : '0;
         pending <= wrap;
      end else if (wrap) begin
         pending <= 1'b1;
         if (picnt != TOP) picnt <= picnt + 1'b1;
      end
   end
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 20,
   parameter int TALLY_W  = 12,
   parameter int PRESCALE = 16,
   parameter int EN_BIT   = 24,
   parameter int IE_BIT   = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import pit_pkg::*;

   initial begin
      if (CNT_W + TALLY_W > DATA_W) $error("interval_tick_timer: fields exceed data width");
      if (EN_BIT < CNT_W || IE_BIT < CNT_W) $error("interval_tick_timer: enable bits overlap period field");
      if (EN_BIT >= DATA_W || IE_BIT >= DATA_W || EN_BIT == IE_BIT) $error("interval_tick_timer: bad enable bit positions");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(bus_addr);

   logic             mode_wr, ack_rd, img_rd;
   logic [CNT_W-1:0] piv;
   logic             en, ie;
   logic             run, tick, pre_zero, wrap, pending;
   logic [CNT_W-1:0] cpiv;
   logic [TALLY_W-1:0] picnt;

   assign mode_wr = bus_wr && (sel == SEL_MODE);
   assign ack_rd  = bus_rd && (sel == SEL_VALUE);
   assign img_rd  = bus_rd && (sel == SEL_IMAGE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         piv <= '0;
         en  <= 1'b0;
         ie  <= 1'b0;
      end else if (mode_wr) begin
         piv <= bus_wdata[CNT_W-1:0];
         en  <= bus_wdata[EN_BIT];
         ie  <= bus_wdata[IE_BIT];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   // keep running until the period in progress has ended at a boundary
   assign run = en || (cpiv != '0) || !pre_zero;

   pit_prescaler #(.DIV(PRESCALE)) i_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .at_zero(pre_zero)
   );

   pit_interval_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .piv(piv), .cpiv(cpiv), .wrap(wrap)
   );

   pit_period_tally #(.TALLY_W(TALLY_W)) i_tally (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack_rd), .picnt(picnt), .pending(pending)
   );

   logic [DATA_W-1:0] mode_word, stat_word, count_word;

   always_comb begin
      mode_word                    = '0;
      mode_word[CNT_W-1:0]         = piv;
      mode_word[EN_BIT]            = en;
      mode_word[IE_BIT]            = ie;
      stat_word                    = '0;
      stat_word[0]                 = pending;
      count_word                   = '0;
      count_word[CNT_W-1:0]        = cpiv;
      count_word[CNT_W +: TALLY_W] = picnt;
   end

   always_comb begin
      unique case (sel)
         SEL_MODE:  bus_rdata = mode_word;
         SEL_STAT:  bus_rdata = stat_word;
         default:   bus_rdata = count_word;
      endcase
   end

   assign irq = pending && ie;
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
   parameter int CNT_W   = 20,
   parameter int TALLY_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack_rd,
   input logic               img_rd,
   input logic               bus_wr,
   input logic               tick,
   input logic               wrap,
   input logic               en,
   input logic               pre_zero,
   input logic               pending,
   input logic               irq,
   input logic [CNT_W-1:0]   cpiv,
   input logic [CNT_W-1:0]   piv,
   input logic [TALLY_W-1:0] picnt
);
   localparam logic [TALLY_W-1:0] TOP = {TALLY_W{1'b1}};

   // R3: the counter only moves on a prescaled tick
   p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cpiv));

   // R3: reaching the period value on a tick returns to zero
   p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cpiv == piv) |=> cpiv == '0);

   // R4: a period end leaves the status bit set
   p_wrap_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> pending);

   // R5: an acknowledge alone clears tally and status
   p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !wrap) |=> (picnt == '0 && !pending));

   // R5: an image read alone disturbs nothing
   p_image_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (img_rd && !wrap) |=> ($stable(picnt) && $stable(pending)));

   // R6: an acknowledge colliding with a period end keeps one pending period
   p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && wrap) |=> (picnt == TALLY_W'(1) && pending));

   // R7: the tally holds at its maximum
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (picnt == TOP && !ack_rd) |=> picnt == TOP);

   // R8: the interrupt level persists until acknowledged or reconfigured
   p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack_rd && !bus_wr) |=> irq);

   // R9: once stopped at a boundary with the enable off, the counter stays at zero
   p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && cpiv == '0 && pre_zero) |=> cpiv == '0);
endmodule

bind interval_tick_timer pit_checker #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) i_pit_chk (
   .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .img_rd(img_rd), .bus_wr(bus_wr),
   .tick(tick), .wrap(wrap), .en(en), .pre_zero(pre_zero), .pending(pending),
   .irq(irq), .cpiv(cpiv), .piv(piv), .picnt(picnt)
);

// File: tb/test_interval_tick_timer.sv
module test_interval_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        irq;

   always #2.5 clk = ~clk;

   interval_tick_timer i_interval_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [31:0] q_data[$];
   logic        q_irq[$];
   string       q_tag[$];

   int cyc = 0;
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // reference model state
   int c0 = 0, nw = 0, stop_tot = 0, tot_base = 0, acked = 0;
   int piv_m = 0, len_m = 16;
   bit en_m = 0, ie_m = 0;
   logic [31:0] mode_m = 32'd0;

   task automatic model(output int cp, output int tot);
      int n, t;
      n = cyc - c0;
      if (!en_m && n >= nw) begin
         cp = 0; tot = stop_tot;
      end else begin
         t = n / 16;
         cp = t % (piv_m + 1);
         tot = tot_base + t / (piv_m + 1);
      end
   endtask

   // monitor: compares each read against the scoreboard
   always begin
      @(negedge clk);
      #1;
      if (bus_rd && !done) begin
         if (q_data.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard empty: read with no expectation, actual=%h expected=none", bus_rdata);
         end else begin
            logic [31:0] ed; logic ei; string tg;
            ed = q_data.pop_front(); ei = q_irq.pop_front(); tg = q_tag.pop_front();
            n_cmp++;
            if (bus_rdata !== ed || irq !== ei) begin
               n_bad++;
               $display("FAIL %s: actual data=%h irq=%b expected data=%h irq=%b", tg, bus_rdata, irq, ed, ei);
            end
         end
      end
   end

   task automatic do_read(input logic [1:0] a, input string tag);
      int cp, tot, pc;
      logic [31:0] ed;
      logic st;
      model(cp, tot);
      pc = tot - acked;
      if (pc > 4095) pc = 4095;
      st = (tot != acked);
      case (a)
         2'd0: ed = mode_m;
         2'd1: ed = {31'd0, st};
         default: ed = {pc[11:0], cp[19:0]};
      endcase
      q_data.push_back(ed); q_irq.push_back(st & ie_m); q_tag.push_back(tag);
      bus_rd = 1'b1; bus_addr = a;
      if (a == 2'd2) acked = tot;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic do_mode(input logic [31:0] d);
      bit new_en;
      new_en = d[24];
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (!en_m && new_en) begin
         tot_base = stop_tot;
         c0 = cyc;
         piv_m = int'(d[19:0]);
         len_m = 16 * (piv_m + 1);
      end else if (en_m && !new_en) begin
         int n1;
         n1 = cyc - c0;
         nw = ((n1 + len_m - 1) / len_m) * len_m;
         stop_tot = tot_base + nw / len_m;
      end else if (!new_en) begin
         piv_m = int'(d[19:0]);
         len_m = 16 * (piv_m + 1);
      end
      en_m = new_en;
      ie_m = d[25];
      mode_m = d & 32'h0300_0000 | {12'd0, d[19:0]};
   endtask

   task automatic wait_n(input int target);
      while ((cyc - c0) < target) @(negedge clk);
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      do_read(2'd0, "R1 mode after reset");
      do_read(2'd1, "R1 status after reset");
      do_read(2'd3, "R1 image after reset");
      do_read(2'd2, "R1 value after reset");

      // R2/R3: period value 5 -> 96 clocks per period, both enables on
      do_mode(32'h0300_0005);
      do_read(2'd0, "R2 mode readback");
      wait_n(328);
      // R4: three unserviced periods accumulate, CPIV=2
      do_read(2'd3, "R4 tally of missed periods");
      do_read(2'd3, "R5 image read leaves tally");
      do_read(2'd1, "R4 status pending");
      do_read(2'd2, "R5 acknowledging read");
      do_read(2'd3, "R5 cleared after acknowledge");
      wait_n(350);
      do_read(2'd3, "R3 counter position mid period");

      // R6: acknowledge in the last cycle of the fourth period
      wait_n(383);
      do_read(2'd2, "R6 acknowledge at period end");
      do_read(2'd3, "R6 collided period still counted");

      // R8: interrupt enable off masks irq while status stays set
      do_mode(32'h0100_0005);
      wait_n(500);
      do_read(2'd1, "R8 irq masked with status set");
      do_mode(32'h0300_0005);
      do_read(2'd1, "R8 irq restored by enable");

      // R9: clear timer enable mid period
      wait_n(530);
      do_mode(32'h0200_0005);
      idle(150);
      do_read(2'd3, "R9 stopped at zero after period");
      idle(200);
      do_read(2'd3, "R9 holds at zero");
      do_read(2'd2, "R9 acknowledge while stopped");

      // R9/R7: restart with period value 0 (16 clocks per period)
      do_mode(32'h0300_0000);
      wait_n(47);
      do_read(2'd3, "R9 prescaler restarted, before third period");
      do_read(2'd3, "R9 prescaler restarted, third period done");
      wait_n(16 * 4100);
      do_read(2'd3, "R7 tally saturated");
      do_read(2'd2, "R7 acknowledge saturated tally");
      do_read(2'd3, "R5 tally cleared after saturation");
      idle(2);
      finish_run();
   end
endmodule